// File: doc/BRIEF.md
# I2C Slave Multi-Address Matcher

This block decides, on the slave side of an I2C-style bus, whether the address phase of a transfer is aimed at this device. A bit-level engine hands it byte-level events: a start, a repeated start, a stop, the first address byte and, for 10-bit addressing, the second address byte. The matcher compares these against every enabled own address. That set is one primary address (7-bit or 10-bit), one secondary 7-bit address with a maskable low end, and four fixed addresses: general call and the three SMBus addresses for alert response, device default and host. The matcher then reports whether to acknowledge, whether a match is held, the transfer direction and a code that names the matched address.

The 10-bit path takes precedence over the 7-bit comparators. Any first byte that carries the 10-bit header prefix is decoded only as a header. A 10-bit write header followed by the matching low byte produces a 10-bit match whose code is built from the header prefix and the two top primary bits, even when the primary's middle bits coincide with an enabled 7-bit address. After such a write match, a repeated start with the matching read header switches the device into slave-transmit with the direction flag set, whatever the primary's low bits are.

Top module: `i2c_addr_matcher`

## Requirements
- R1: After reset addr_ack, addr_match and xfer_dir are 0 and addr_code is 0.
- R2: With the primary enabled in 7-bit mode, a first byte whose bits 7:1 equal primary bits 6:0 gives, on the clock edge that samples ev_addr1, addr_ack high for one cycle, addr_match high, addr_code equal to byte bits 7:1 and xfer_dir equal to byte bit 0.
- R3: The secondary address matches when, after the low cfg_sec_mask bits (0 to 7) are ignored, the remaining bits of byte bits 7:1 equal those of cfg_sec_addr. A mask of 7 matches every 7-bit address outside the 10-bit header range.
- R4: Address 0x00 (general call), 0x0C (alert response), 0x61 (device default) and 0x08 (host) each match only while their own enable is 1.
- R5: With a 10-bit primary, a first byte 11110 followed by primary bits 9:8 and then 0 is acknowledged with addr_match low and addr_code 0. An ev_addr2 byte equal to primary bits 7:0 then gives a match with xfer_dir 0. Any other second byte gives no acknowledge and no match.
- R6: A first byte whose bits 7:3 are 11110 is never decoded as a 7-bit address. A 10-bit match reports addr_code = {11110, primary bits 9:8}, even when primary bits 7:1 equal an enabled 7-bit address.
- R7: After a completed 10-bit write match and a repeated start, the read header (bit 0 = 1) with matching top bits is acknowledged with addr_match 1, xfer_dir 1 and the 10-bit code, for any primary low bits.
- R8: A read header after a plain start, with no 10-bit write match before it, is neither acknowledged nor matched.
- R9: A stop, a start or a repeated start clears addr_match, xfer_dir and addr_code on the next edge. A first byte that matches nothing does the same and gives no acknowledge. A stop or a plain start also forgets any earlier 10-bit write match.
- R10: With cfg_pri_en or cfg_sec_en at 0, that address never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_pri_en | input | 1 | Primary address enable |
| cfg_pri_10b | input | 1 | Primary is a 10-bit address |
| cfg_pri_addr | input | 10 | Primary address (bits 6:0 used in 7-bit mode) |
| cfg_sec_en | input | 1 | Secondary address enable |
| cfg_sec_addr | input | 7 | Secondary 7-bit address |
| cfg_sec_mask | input | 3 | Number of low secondary bits ignored |
| cfg_gc_en | input | 1 | General call enable |
| cfg_alert_en | input | 1 | SMBus alert response address enable |
| cfg_dflt_en | input | 1 | SMBus device default address enable |
| cfg_host_en | input | 1 | SMBus host address enable |
| ev_start | input | 1 | Start condition seen (pulse) |
| ev_rstart | input | 1 | Repeated start seen (pulse) |
| ev_stop | input | 1 | Stop condition seen (pulse) |
| ev_addr1 | input | 1 | First address byte valid on rx_byte (pulse) |
| ev_addr2 | input | 1 | Second 10-bit address byte valid on rx_byte (pulse) |
| rx_byte | input | 8 | Received byte |
| addr_ack | output | 1 | Acknowledge the byte just received (one-cycle pulse) |
| addr_match | output | 1 | Device is addressed |
| xfer_dir | output | 1 | 1 = slave transmits (read), 0 = slave receives |
| addr_code | output | 7 | Code of the matched address |

## Verification
On every cycle the assertions check the following. An acknowledge always comes from a byte event. A stop always drops the match. A match held in 7-bit primary mode never carries a header-range code. No match is reported while the low byte of a 10-bit address is still awaited. A matching read header or low byte always yields the 10-bit code with the right direction. Only the bench's scenarios can show the mask arithmetic across all 128 addresses and eight mask values, the enable gating of each fixed address, and the precedence of the 10-bit match over a coinciding secondary. The same holds for the read header after a repeated start when the primary's low byte itself looks like a header, and for the loss of 10-bit history at a plain start.

// File: rtl/i2c_match_pkg.sv
package i2c_match_pkg;

  localparam int A7_W      = 7;
  localparam int A10_W     = 10;
  localparam int BYTE_W    = 8;
  localparam int MASK_W    = 3;
  localparam int NUM_FIXED = 4;
  localparam logic [4:0] HDR_PREFIX = 5'b11110;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT_LO = 2'd1,
    ST_MATCH   = 2'd2
  } match_st_t;

  // Fixed addresses: 0 general call, 1 alert, 2 device default, 3 host
  function automatic logic [A7_W-1:0] fixed_addr(input int idx);
    case (idx)
      0:       return 7'h00;
      1:       return 7'h0C;
      2:       return 7'h61;
      default: return 7'h08;
    endcase
  endfunction

  // Compare a and b ignoring the lowest m bits
  function automatic logic masked_eq(input logic [A7_W-1:0] a,
                                     input logic [A7_W-1:0] b,
                                     input logic [MASK_W-1:0] m);
    logic [A7_W-1:0] keep;
    keep = {A7_W{1'b1}} << m;
    return ((a ^ b) & keep) == '0;
  endfunction

  function automatic logic is_hdr_form(input logic [BYTE_W-1:0] b);
    return b[7:3] == HDR_PREFIX;
  endfunction

  function automatic logic [A7_W-1:0] code10(input logic [1:0] hi);
    return {HDR_PREFIX, hi};
  endfunction

endpackage

// File: rtl/i2c_match_seven.sv
module i2c_match_seven
  import i2c_match_pkg::*;
(
  input  logic [A7_W-1:0]      a7,
  input  logic                 pri_en,
  input  logic                 pri_10b,
  input  logic [A7_W-1:0]      pri_lo7,
  input  logic                 sec_en,
  input  logic [A7_W-1:0]      sec_addr,
  input  logic [MASK_W-1:0]    sec_mask,
  input  logic [NUM_FIXED-1:0] fix_en,
  output logic                 any_hit
);
  localparam int NHIT = NUM_FIXED + 2;

  logic [NHIT-1:0] hit_vec;

  assign hit_vec[0] = pri_en && !pri_10b && (a7 == pri_lo7);
  assign hit_vec[1] = sec_en && masked_eq(a7, sec_addr, sec_mask);

  for (genvar g = 0; g < NUM_FIXED; g++) begin : g_fixed
    assign hit_vec[g+2] = fix_en[g] && (a7 == fixed_addr(g));
  end

  assign any_hit = |hit_vec;
endmodule

// File: rtl/i2c_match_hdr.sv
module i2c_match_hdr
  import i2c_match_pkg::*;
(
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              pri_en,
  input  logic              pri_10b,
  input  logic [1:0]        pri_hi,
  output logic              hdr_form,
  output logic              hdr_hit,
  output logic              hdr_rd
);
  assign hdr_form = is_hdr_form(rx_byte);
  assign hdr_hit  = hdr_form && pri_en && pri_10b && (rx_byte[2:1] == pri_hi);
  assign hdr_rd   = rx_byte[0];
endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
  import i2c_match_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_pri_en,
  input  logic              cfg_pri_10b,
  input  logic [A10_W-1:0]  cfg_pri_addr,
  input  logic              cfg_sec_en,
  input  logic [A7_W-1:0]   cfg_sec_addr,
  input  logic [MASK_W-1:0] cfg_sec_mask,
  input  logic              cfg_gc_en,
  input  logic              cfg_alert_en,
  input  logic              cfg_dflt_en,
  input  logic              cfg_host_en,
  input  logic              ev_start,
  input  logic              ev_rstart,
  input  logic              ev_stop,
  input  logic              ev_addr1,
  input  logic              ev_addr2,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              addr_ack,
  output logic              addr_match,
  output logic              xfer_dir,
  output logic [A7_W-1:0]   addr_code
);
  match_st_t       st_q;
  logic            done10_q;
  logic            ack_q, match_q, dir_q;
  logic [A7_W-1:0] code_q;

  logic hdr_form, hdr_hit, hdr_rd, seven_hit;

  i2c_match_hdr i_hdr (
    .rx_byte (rx_byte),
    .pri_en  (cfg_pri_en),
    .pri_10b (cfg_pri_10b),
    .pri_hi  (cfg_pri_addr[9:8]),
    .hdr_form(hdr_form),
    .hdr_hit (hdr_hit),
    .hdr_rd  (hdr_rd)
  );

  i2c_match_seven i_seven (
    .a7      (rx_byte[7:1]),
    .pri_en  (cfg_pri_en),
    .pri_10b (cfg_pri_10b),
    .pri_lo7 (cfg_pri_addr[6:0]),
    .sec_en  (cfg_sec_en),
    .sec_addr(cfg_sec_addr),
    .sec_mask(cfg_sec_mask),
    .fix_en  ({cfg_host_en, cfg_dflt_en, cfg_alert_en, cfg_gc_en}),
    .any_hit (seven_hit)
  );

  // Named internal events
  logic ev_bus_reset, evt_seven_ok, evt_hdr_wr_ok, evt_hdr_rd_ok;
  logic evt_lo_ok, evt_lo_bad;

  assign ev_bus_reset  = ev_stop || ev_start;
  assign evt_seven_ok  = ev_addr1 && !hdr_form && seven_hit;
  assign evt_hdr_wr_ok = ev_addr1 && hdr_hit && !hdr_rd;
  assign evt_hdr_rd_ok = ev_addr1 && hdr_hit && hdr_rd && done10_q;
  assign evt_lo_ok     = ev_addr2 && (st_q == ST_WAIT_LO)
                         && (rx_byte == cfg_pri_addr[7:0]);
  assign evt_lo_bad    = ev_addr2 && (st_q == ST_WAIT_LO) && !evt_lo_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      done10_q <= 1'b0;
      ack_q    <= 1'b0;
      match_q  <= 1'b0;
      dir_q    <= 1'b0;
      code_q   <= '0;
    end else begin
      ack_q <= 1'b0;
      if (ev_bus_reset || ev_rstart) begin
        st_q    <= ST_IDLE;
        match_q <= 1'b0;
        dir_q   <= 1'b0;
        code_q  <= '0;
        if (ev_bus_reset) done10_q <= 1'b0;
      end else if (ev_addr1) begin
        ack_q <= evt_seven_ok || evt_hdr_wr_ok || evt_hdr_rd_ok;
        if (evt_seven_ok) begin
          st_q    <= ST_MATCH;
          match_q <= 1'b1;
          dir_q   <= rx_byte[0];
          code_q  <= rx_byte[7:1];
        end else if (evt_hdr_rd_ok) begin
          st_q    <= ST_MATCH;
          match_q <= 1'b1;
          dir_q   <= 1'b1;
          code_q  <= code10(cfg_pri_addr[9:8]);
        end else begin
          st_q    <= evt_hdr_wr_ok ? ST_WAIT_LO : ST_IDLE;
          match_q <= 1'b0;
          dir_q   <= 1'b0;
          code_q  <= '0;
        end
      end else if (evt_lo_ok) begin
        ack_q    <= 1'b1;
        st_q     <= ST_MATCH;
        match_q  <= 1'b1;
        dir_q    <= 1'b0;
        code_q   <= code10(cfg_pri_addr[9:8]);
        done10_q <= 1'b1;
      end else if (evt_lo_bad) begin
        st_q <= ST_IDLE;
      end
    end
  end

  assign addr_ack   = ack_q;
  assign addr_match = match_q;
  assign xfer_dir   = dir_q;
  assign addr_code  = code_q;

  // R2: an acknowledge is only given for a byte just received
  assert_ack_from_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ack |-> $past(ev_addr1 || ev_addr2));

  // R9: a stop always drops the match and the acknowledge
  assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (!addr_match && !addr_ack));

  // R5: no match while the low byte of a 10-bit address is awaited
  assert_wait_no_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT_LO) |-> !addr_match);

  // R6: a matching low byte yields the 10-bit code, write direction
  assert_lo_code10_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_lo_ok |=> (addr_match && addr_ack && !xfer_dir &&
                   addr_code == {HDR_PREFIX, $past(cfg_pri_addr[9:8])}));

  // R7: accepted read header sets direction to slave-transmit
  assert_rd_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hdr_rd_ok |=> (addr_match && xfer_dir && addr_code[6:2] == HDR_PREFIX));

  // R6: in 7-bit primary mode a held match never carries a header-range code
  assert_no_hdr_as7_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_match && !cfg_pri_10b && $stable(cfg_pri_10b))
      |-> addr_code[6:2] != HDR_PREFIX);

endmodule

// File: tb/test_i2c_addr_matcher.sv
module test_i2c_addr_matcher;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_pri_en = 0, cfg_pri_10b = 0, cfg_sec_en = 0;
  logic [9:0] cfg_pri_addr = '0;
  logic [6:0] cfg_sec_addr = '0;
  logic [2:0] cfg_sec_mask = '0;
  logic       cfg_gc_en = 0, cfg_alert_en = 0, cfg_dflt_en = 0, cfg_host_en = 0;
  logic       ev_start = 0, ev_rstart = 0, ev_stop = 0, ev_addr1 = 0, ev_addr2 = 0;
  logic [7:0] rx_byte = '0;
  logic       addr_ack, addr_match, xfer_dir;
  logic [6:0] addr_code;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  bit due = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  i2c_addr_matcher i_i2c_addr_matcher (.*);

  // expected packing: {ack, match, dir, code[6:0]}
  function automatic logic [9:0] pack(input logic a, input logic m,
                                      input logic d, input logic [6:0] c);
    return {a, m, d, c};
  endfunction

  // Independent 7-bit model
  function automatic logic [9:0] model7(input logic [7:0] b);
    logic [6:0] a;
    logic hit;
    int sh;
    a = b[7:1];
    if (a[6:2] == 5'b11110) return '0;
    sh = int'(cfg_sec_mask);
    hit = 1'b0;
    if (cfg_pri_en && !cfg_pri_10b && a == cfg_pri_addr[6:0]) hit = 1'b1;
    if (cfg_sec_en && (sh == 7 || (a >> sh) == (cfg_sec_addr >> sh))) hit = 1'b1;
    if (cfg_gc_en && a == 7'd0) hit = 1'b1;
    if (cfg_alert_en && a == 7'd12) hit = 1'b1;
    if (cfg_dflt_en && a == 7'd97) hit = 1'b1;
    if (cfg_host_en && a == 7'd8) hit = 1'b1;
    return hit ? pack(1'b1, 1'b1, b[0], a) : '0;
  endfunction

  // kind: 0 start, 1 rstart, 2 stop, 3 first byte, 4 second byte
  task automatic drive(input int kind, input logic [7:0] b,
                       input logic [9:0] exp, input string tag);
    @(negedge clk);
    ev_start  = (kind == 0);
    ev_rstart = (kind == 1);
    ev_stop   = (kind == 2);
    ev_addr1  = (kind == 3);
    ev_addr2  = (kind == 4);
    rx_byte   = b;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    due = 1'b1;
    @(posedge clk);
    #6;
    {ev_start, ev_rstart, ev_stop, ev_addr1, ev_addr2} = '0;
  endtask

  // Monitor: compares just after the edge that samples each event
  initial forever begin
    @(posedge clk);
    #3;
    if (due) begin
      logic [9:0] e, got;
      string t;
      due = 1'b0;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      got = {addr_ack, addr_match, xfer_dir, addr_code};
      n_cmp++;
      if (got !== e) begin
        n_bad++;
        $display("FAIL %s: got ack=%b match=%b dir=%b code=%h, expected ack=%b match=%b dir=%b code=%h",
                 t, got[9], got[8], got[7], got[6:0], e[9], e[8], e[7], e[6:0]);
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #3;
    n_cmp++;
    if ({addr_ack, addr_match, xfer_dir, addr_code} !== 10'd0) begin
      n_bad++;
      $display("FAIL R1 reset: got %h, expected 000", {addr_ack, addr_match, xfer_dir, addr_code});
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R2: 7-bit primary 0x35
    cfg_pri_en = 1; cfg_pri_10b = 0; cfg_pri_addr = 10'h035;
    drive(0, 8'h00, '0, "R9 start");
    drive(3, 8'h6B, pack(1, 1, 1, 7'h35), "R2 primary read");
    drive(2, 8'h00, '0, "R9 stop clears");
    drive(3, 8'h6A, pack(1, 1, 0, 7'h35), "R2 primary write");
    drive(3, 8'h6C, '0, "R9 non-match clears");

    // R10: primary disabled
    cfg_pri_en = 0;
    drive(3, 8'h6A, '0, "R10 primary disabled");

    // R4: fixed addresses gated by enables
    drive(3, 8'h00, '0, "R4 general call off");
    cfg_gc_en = 1;
    drive(3, 8'h00, pack(1, 1, 0, 7'h00), "R4 general call on");
    drive(3, 8'h19, '0, "R4 alert off");
    cfg_alert_en = 1;
    drive(3, 8'h19, pack(1, 1, 1, 7'h0C), "R4 alert on");
    drive(3, 8'hC2, '0, "R4 device default off");
    cfg_dflt_en = 1;
    drive(3, 8'hC2, pack(1, 1, 0, 7'h61), "R4 device default on");
    drive(3, 8'h10, '0, "R4 host off");
    cfg_host_en = 1;
    drive(3, 8'h10, pack(1, 1, 0, 7'h08), "R4 host on");
    {cfg_gc_en, cfg_alert_en, cfg_dflt_en, cfg_host_en} = '0;

    // R3/R6/R10: sweep secondary masks over every address with model
    cfg_pri_en = 1; cfg_pri_addr = 10'h035; cfg_sec_addr = 7'h52;
    for (int en = 0; en < 2; en++) begin
      cfg_sec_en = en[0];
      for (int m = 0; m < 8; m++) begin
        cfg_sec_mask = m[2:0];
        for (int a = 0; a < 128; a++) begin
          logic [7:0] b;
          b = {a[6:0], a[0] ^ a[3]};
          drive(3, b, model7(b), "R3 R6 R10 mask sweep");
        end
      end
    end

    // R5/R6/R7/R8: 10-bit primary 0x2AA with coinciding secondary 0x55
    cfg_pri_10b = 1; cfg_pri_addr = 10'h2AA;
    cfg_sec_en = 1; cfg_sec_addr = 7'h55; cfg_sec_mask = 3'd0;
    drive(0, 8'h00, '0, "R9 start");
    drive(3, 8'hF4, pack(1, 0, 0, 7'h00), "R5 write header acked");
    drive(4, 8'hAA, pack(1, 1, 0, 7'h7A), "R5 R6 low byte match 10-bit code");
    drive(1, 8'h00, '0, "R9 rstart clears outputs");
    drive(3, 8'hF5, pack(1, 1, 1, 7'h7A), "R7 read header after rstart");
    drive(1, 8'h00, '0, "R9 rstart");
    drive(3, 8'hF3, '0, "R7 read header wrong top bits");
    drive(2, 8'h00, '0, "R9 stop");
    drive(0, 8'h00, '0, "R9 start");
    drive(3, 8'hF5, '0, "R8 read header without write");
    drive(0, 8'h00, '0, "R9 start");
    drive(3, 8'hF4, pack(1, 0, 0, 7'h00), "R5 write header acked");
    drive(4, 8'hAB, '0, "R5 wrong low byte");
    drive(1, 8'h00, '0, "R9 rstart");
    drive(3, 8'hF5, '0, "R8 read header after failed low byte");
    drive(3, 8'hAA, pack(1, 1, 0, 7'h55), "R3 secondary alongside 10-bit");
    drive(3, 8'hF0, '0, "R6 header form never 7-bit");

    // R7: primary whose low byte looks like a read header
    cfg_pri_addr = 10'h0F1; cfg_sec_en = 1; cfg_sec_addr = 7'h78; cfg_sec_mask = 3'd7;
    drive(2, 8'h00, '0, "R9 stop");
    drive(0, 8'h00, '0, "R9 start");
    drive(3, 8'hF0, pack(1, 0, 0, 7'h00), "R5 write header acked");
    drive(4, 8'hF1, pack(1, 1, 0, 7'h78), "R6 10-bit code wins");
    drive(1, 8'h00, '0, "R9 rstart");
    drive(3, 8'hF1, pack(1, 1, 1, 7'h78), "R7 read header dir set");
    drive(2, 8'h00, '0, "R9 stop");

    repeat (3) @(posedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule